// File: doc/BRIEF.md
# Loopback Test Function Controller

This block is a register-driven test engine for exercising a host's view of an endpoint. A host programs a scratch pattern, a source address, a destination address, a byte length, an interrupt kind and an interrupt vector through a small word-indexed register window. It then sets one command bit. The engine reads a host buffer, writes a host buffer, copies one host buffer to another, or only raises an interrupt.

The host buffers are reached through a generic memory-request port. That port has a valid/ready request handshake and a single-cycle response that carries data and an error flag. When a command finishes, its outcome is recorded in a status word. A one-cycle interrupt request is emitted with a kind (0 legacy, 1 MSI, 2 MSI-X) and a vector number. The request is emitted only if the vector is legal for that kind.

Top module: `lbk_test_engine`

## Requirements
- R1: Register index 0 is a scratch pattern register. Any 32-bit value written there reads back unchanged.
- R2: The register indices on `reg_addr` are: 0 pattern, 1 command, 2 status (read-only), 3 source address, 4 destination address, 5 byte length, 6 interrupt kind (2 bits), 7 interrupt vector (16 bits). Command bits are: 0 raise legacy, 1 raise MSI, 2 raise MSI-X, 3 read, 4 write, 5 copy. When several bits are set, the lowest set bit is honoured. A command write made while a command is pending is ignored.
- R3: The command register reads back its value while the command runs and clears itself when the command completes. Accepting a new command clears every status bit.
- R4: A read command fetches ceil(length/4) consecutive words starting at the source address. Success sets status bit 0; failure sets status bit 1.
- R5: A write command stores the pattern register value into ceil(length/4) consecutive words starting at the destination address. Success sets status bit 2; failure sets status bit 3.
- R6: A copy command moves ceil(length/4) words from source to destination one word at a time. Success sets status bit 4; failure sets status bit 5.
- R7: Before any memory request, an address is checked. An address that is not 4-byte aligned, or whose span does not fit inside the `WIN_BYTES` window starting at 0, is rejected. A rejected source sets status bit 7 and a rejected destination sets status bit 8. The operation's fail bit is also set, and no memory request is issued.
- R8: A memory response with its error flag set ends the operation at once. The fail bit is set and no further requests are issued.
- R9: After a read, write or copy, an interrupt of the programmed kind is requested. It is requested only if the vector is 0 for legacy, 1..32 for MSI, or 1..2048 for MSI-X. Any other vector, or kind 3, suppresses the request.
- R10: Command bits 0, 1 and 2 touch no memory. They request an interrupt of kind 0, 1 or 2 respectively, using the programmed vector and the range rule of R9.
- R11: An interrupt request is a single-cycle pulse on `irq_pulse` with `irq_kind` and `irq_vec` valid in that cycle. Status bit 6 is set exactly when a request was issued.
- R12: A memory request held while `mem_req_ready` is low keeps its address, write flag and data unchanged.
- R13: A length of 0 with valid addresses completes with the success bit set and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response valid, one per accepted request |
| mem_rsp_err | input | 1 | Response error flag |
| mem_rsp_data | input | 32 | Read response data |
| irq_pulse | output | 1 | Interrupt request pulse |
| irq_kind | output | 2 | Interrupt kind of the pulse |
| irq_vec | output | 16 | Interrupt vector of the pulse |

## Verification
The bench targets several corner cases.

- **Vector range edges** (0/1, 32/33, 2048/2049 and kind 3): an off-by-one range check would pulse where it must stay quiet, or stay quiet where it must pulse.
- **Rejected addresses**: a misaligned source and a destination whose span ends past the window must produce zero accepted requests. A checker that runs after the first access would show up in the request count.
- **Error response on the middle word of a read**: a design that ignores the error would report success and issue a fourth request.
- **Combined read and write bits**: a priority encoder built the wrong way round would write the destination.
- **Command written while busy**: a design that accepts it would disturb the running copy's status.
- **Random copies of random lengths, including 0**: these check word counts, and check that the word past the end is untouched.

// File: rtl/lbk_pkg.sv
// Shared register indices, operation codes and status bit positions for
// the loopback test engine. Assumes a 3-bit word-indexed register window.
package lbk_pkg;

    typedef enum logic [2:0] {
        RI_PATTERN = 3'd0,
        RI_CMD     = 3'd1,
        RI_STATUS  = 3'd2,
        RI_SRC     = 3'd3,
        RI_DST     = 3'd4,
        RI_LEN     = 3'd5,
        RI_KIND    = 3'd6,
        RI_VEC     = 3'd7
    } reg_idx_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_RAISE_LEG, OP_RAISE_MSI, OP_RAISE_MSIX,
        OP_READ, OP_WRITE, OP_COPY
    } op_e;

    localparam int CMD_W    = 6;
    localparam int STAT_W   = 9;
    localparam int ST_RD_OK = 0;
    localparam int ST_RD_NG = 1;
    localparam int ST_WR_OK = 2;
    localparam int ST_WR_NG = 3;
    localparam int ST_CP_OK = 4;
    localparam int ST_CP_NG = 5;
    localparam int ST_IRQ   = 6;
    localparam int ST_SRC_X = 7;
    localparam int ST_DST_X = 8;

    // Lowest set command bit wins
    function automatic op_e pick_op(input logic [CMD_W-1:0] c);
        if (c[0])      return OP_RAISE_LEG;
        else if (c[1]) return OP_RAISE_MSI;
        else if (c[2]) return OP_RAISE_MSIX;
        else if (c[3]) return OP_READ;
        else if (c[4]) return OP_WRITE;
        else if (c[5]) return OP_COPY;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/lbk_regs.sv
// Register bank of the test engine: pattern, addresses, length, interrupt
// kind/vector and the self-clearing command word. Assumes the sequencer
// reports completion with a one-cycle done strobe.
module lbk_regs
    import lbk_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             done,
    output logic             start,
    output op_e              start_op,
    output logic [DW-1:0]    pattern,
    output logic [DW-1:0]    src,
    output logic [DW-1:0]    dst,
    output logic [DW-1:0]    len,
    output logic [1:0]       kind,
    output logic [NUM_W-1:0] vec,
    output logic [CMD_W-1:0] cmd_q
);

    reg_idx_e idx;
    assign idx = reg_idx_e'(reg_addr);

    // Accept a non-empty command only when nothing is pending
    assign start    = reg_wr && (idx == RI_CMD) && (cmd_q == '0) && (reg_wdata[CMD_W-1:0] != '0);
    assign start_op = pick_op(reg_wdata[CMD_W-1:0]);

    // Register writes and command set/clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern <= '0;
            src     <= '0;
            dst     <= '0;
            len     <= '0;
            kind    <= '0;
            vec     <= '0;
            cmd_q   <= '0;
        end else begin
            if (reg_wr) begin
                case (idx)
                    RI_PATTERN: pattern <= reg_wdata;
                    RI_SRC:     src     <= reg_wdata;
                    RI_DST:     dst     <= reg_wdata;
                    RI_LEN:     len     <= reg_wdata;
                    RI_KIND:    kind    <= reg_wdata[1:0];
                    RI_VEC:     vec     <= reg_wdata[NUM_W-1:0];
                    default:    ;
                endcase
            end
            if (start)     cmd_q <= reg_wdata[CMD_W-1:0];
            else if (done) cmd_q <= '0;
        end
    end

    p_pattern_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && idx == RI_PATTERN) |=> (pattern == $past(reg_wdata)));

    p_cmd_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cmd_q == '0));

    p_busy_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != '0 && !done) |=> $stable(cmd_q));

endmodule

// File: rtl/lbk_irq.sv
// Interrupt request stage: checks the vector against the range allowed for
// the kind and emits a registered one-cycle pulse. Assumes fire is high for
// a single cycle per command.
module lbk_irq #(
    parameter int NUM_W    = 16,
    parameter int MSI_MAX  = 32,
    parameter int MSIX_MAX = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [1:0]       kind_in,
    input  logic [NUM_W-1:0] vec_in,
    output logic             accept,
    output logic             irq_pulse,
    output logic [1:0]       irq_kind,
    output logic [NUM_W-1:0] irq_vec
);

    logic legal;

    // Range rule per interrupt kind
    always_comb begin
        case (kind_in)
            2'd0:    legal = (vec_in == '0);
            2'd1:    legal = (vec_in != '0) && (32'(vec_in) <= MSI_MAX);
            2'd2:    legal = (vec_in != '0) && (32'(vec_in) <= MSIX_MAX);
            default: legal = 1'b0;
        endcase
    end

    assign accept = fire && legal;

    // Register the pulse with its tag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
            irq_kind  <= '0;
            irq_vec   <= '0;
        end else begin
            irq_pulse <= accept;
            if (accept) begin
                irq_kind <= kind_in;
                irq_vec  <= vec_in;
            end
        end
    end

    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    p_vec_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ((irq_kind == 2'd0 && irq_vec == '0) ||
                       (irq_kind == 2'd1 && irq_vec != '0 && 32'(irq_vec) <= MSI_MAX) ||
                       (irq_kind == 2'd2 && irq_vec != '0 && 32'(irq_vec) <= MSIX_MAX)));

endmodule

// File: rtl/lbk_seq.sv
// Command sequencer: checks addresses, walks the words of a read, write or
// copy over the memory port, keeps the status word and fires the interrupt
// stage on completion. Assumes one response per accepted request.
module lbk_seq
    import lbk_pkg::*;
#(
    parameter int DW        = 32,
    parameter int WIN_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_e               start_op,
    input  logic [DW-1:0]     src,
    input  logic [DW-1:0]     dst,
    input  logic [DW-1:0]     len,
    input  logic [DW-1:0]     pattern,
    input  logic [1:0]        kind,
    input  logic              irq_accept,
    output logic              done,
    output logic              fire,
    output logic [1:0]        fire_kind,
    output logic [STAT_W-1:0] status,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [DW-1:0]     mem_req_addr,
    output logic [DW-1:0]     mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [DW-1:0]     mem_rsp_data
);

    localparam int WC_W = DW - 1;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_RREQ, S_RWAIT, S_WREQ, S_WWAIT, S_DONE
    } st_e;

    st_e            st;
    op_e            op_q;
    logic [DW-1:0]  src_q, dst_q, hold;
    logic [WC_W-1:0] words_q, idx;
    logic           need_src, need_dst, src_bad, dst_bad, last;
    logic [3:0]     ok_bit, ng_bit;

    // Byte length rounded up to whole words
    function automatic logic [WC_W-1:0] word_count(input logic [DW-1:0] l);
        logic [DW:0] t;
        t = {1'b0, l} + (DW+1)'(3);
        return t[DW:2];
    endfunction

    // Reject misaligned addresses and spans leaving the window
    function automatic logic span_bad(input logic [DW-1:0] a, input logic [WC_W-1:0] w);
        logic [DW+1:0] fin;
        fin = {2'b00, a} + {1'b0, w, 2'b00};
        return (a[1:0] != 2'b00) || ({2'b00, a} >= (DW+2)'(WIN_BYTES)) ||
               (fin > (DW+2)'(WIN_BYTES));
    endfunction

    // Per-operation decode of address needs and status bit positions
    always_comb begin
        need_src = (op_q == OP_READ) || (op_q == OP_COPY);
        need_dst = (op_q == OP_WRITE) || (op_q == OP_COPY);
        case (op_q)
            OP_READ:  begin ok_bit = 4'(ST_RD_OK); ng_bit = 4'(ST_RD_NG); end
            OP_WRITE: begin ok_bit = 4'(ST_WR_OK); ng_bit = 4'(ST_WR_NG); end
            default:  begin ok_bit = 4'(ST_CP_OK); ng_bit = 4'(ST_CP_NG); end
        endcase
        src_bad = span_bad(src_q, words_q);
        dst_bad = span_bad(dst_q, words_q);
        last    = ((idx + 1'b1) == words_q);
    end

    // Memory request and interrupt hand-off from the state
    assign mem_req_valid = (st == S_RREQ) || (st == S_WREQ);
    assign mem_req_write = (st == S_WREQ);
    assign mem_req_addr  = (st == S_WREQ ? dst_q : src_q) + {idx, 2'b00};
    assign mem_req_wdata = (op_q == OP_COPY) ? hold : pattern;
    assign done          = (st == S_DONE);
    assign fire          = (st == S_DONE);

    // Interrupt kind: fixed by raise commands, programmed otherwise
    always_comb begin
        case (op_q)
            OP_RAISE_LEG:  fire_kind = 2'd0;
            OP_RAISE_MSI:  fire_kind = 2'd1;
            OP_RAISE_MSIX: fire_kind = 2'd2;
            default:       fire_kind = kind;
        endcase
    end

    // Sequencer state, word walk and status updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            op_q    <= OP_NONE;
            src_q   <= '0;
            dst_q   <= '0;
            words_q <= '0;
            idx     <= '0;
            hold    <= '0;
            status  <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    op_q    <= start_op;
                    src_q   <= src;
                    dst_q   <= dst;
                    words_q <= word_count(len);
                    idx     <= '0;
                    status  <= '0;
                    st      <= (start_op == OP_READ || start_op == OP_WRITE ||
                                start_op == OP_COPY) ? S_CHECK : S_DONE;
                end
                S_CHECK: begin
                    if (need_src && src_bad) status[ST_SRC_X] <= 1'b1;
                    if (need_dst && dst_bad) status[ST_DST_X] <= 1'b1;
                    if ((need_src && src_bad) || (need_dst && dst_bad)) begin
                        status[ng_bit] <= 1'b1;
                        st             <= S_DONE;
                    end else if (words_q == '0) begin
                        status[ok_bit] <= 1'b1;
                        st             <= S_DONE;
                    end else begin
                        st <= (op_q == OP_WRITE) ? S_WREQ : S_RREQ;
                    end
                end
                S_RREQ: if (mem_req_ready) st <= S_RWAIT;
                S_WREQ: if (mem_req_ready) st <= S_WWAIT;
                S_RWAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        status[ng_bit] <= 1'b1;
                        st             <= S_DONE;
                    end else begin
                        hold <= mem_rsp_data;
                        if (op_q == OP_COPY) begin
                            st <= S_WREQ;
                        end else if (last) begin
                            status[ok_bit] <= 1'b1;
                            st             <= S_DONE;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= S_RREQ;
                        end
                    end
                end
                S_WWAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        status[ng_bit] <= 1'b1;
                        st             <= S_DONE;
                    end else if (last) begin
                        status[ok_bit] <= 1'b1;
                        st             <= S_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= (op_q == OP_COPY) ? S_RREQ : S_WREQ;
                    end
                end
                S_DONE: begin
                    if (irq_accept) status[ST_IRQ] <= 1'b1;
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
             $stable(mem_req_wdata)));

    p_no_access_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_SRC_X] || status[ST_DST_X]) |-> !mem_req_valid);

    p_ok_ng_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !((status[ST_RD_OK] && status[ST_RD_NG]) || (status[ST_WR_OK] && status[ST_WR_NG]) ||
          (status[ST_CP_OK] && status[ST_CP_NG])));

    p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status[ST_CP_NG:ST_RD_OK]) <= 1);

endmodule

// File: rtl/lbk_test_engine.sv
// Top of the loopback test engine: register bank, command sequencer and
// interrupt stage, plus the register read mux. Assumes register reads are
// sampled combinationally from reg_addr.
module lbk_test_engine
    import lbk_pkg::*;
#(
    parameter int DW        = 32,
    parameter int NUM_W     = 16,
    parameter int WIN_BYTES = 4096,
    parameter int MSI_MAX   = 32,
    parameter int MSIX_MAX  = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [DW-1:0]    mem_req_addr,
    output logic [DW-1:0]    mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_err,
    input  logic [DW-1:0]    mem_rsp_data,
    output logic             irq_pulse,
    output logic [1:0]       irq_kind,
    output logic [NUM_W-1:0] irq_vec
);

    logic              start, done, fire, accept;
    op_e               start_op;
    logic [DW-1:0]     pattern, src, dst, len;
    logic [1:0]        kind, fire_kind;
    logic [NUM_W-1:0]  vec;
    logic [CMD_W-1:0]  cmd_q;
    logic [STAT_W-1:0] status;

    lbk_regs #(.DW(DW), .NUM_W(NUM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .done(done), .start(start), .start_op(start_op),
        .pattern(pattern), .src(src), .dst(dst), .len(len), .kind(kind),
        .vec(vec), .cmd_q(cmd_q)
    );

    lbk_seq #(.DW(DW), .WIN_BYTES(WIN_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
        .src(src), .dst(dst), .len(len), .pattern(pattern), .kind(kind),
        .irq_accept(accept), .done(done), .fire(fire), .fire_kind(fire_kind),
        .status(status), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data)
    );

    lbk_irq #(.NUM_W(NUM_W), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)) u_irq (
        .clk(clk), .rst_n(rst_n), .fire(fire), .kind_in(fire_kind), .vec_in(vec),
        .accept(accept), .irq_pulse(irq_pulse), .irq_kind(irq_kind), .irq_vec(irq_vec)
    );

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_idx_e'(reg_addr))
            RI_PATTERN: reg_rdata = pattern;
            RI_CMD:     reg_rdata[CMD_W-1:0]  = cmd_q;
            RI_STATUS:  reg_rdata[STAT_W-1:0] = status;
            RI_SRC:     reg_rdata = src;
            RI_DST:     reg_rdata = dst;
            RI_LEN:     reg_rdata = len;
            RI_KIND:    reg_rdata[1:0] = kind;
            RI_VEC:     reg_rdata[NUM_W-1:0] = vec;
            default:    reg_rdata = '0;
        endcase
    end

    p_irq_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> status[ST_IRQ]);

endmodule

// File: tb/lbk_test_engine_test.sv
module lbk_test_engine_test;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        irq_pulse;
    logic [1:0]  irq_kind;
    logic [15:0] irq_vec;

    int checks = 0, errors = 0;
    int irq_cnt = 0, acc_cnt = 0, irq_base, acc_base;
    logic [1:0]  last_kind;
    logic [15:0] last_vec;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] bmem [0:1023];
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    lbk_test_engine uut (.*);

    // Host memory model: one-cycle response, random ready
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            acc_cnt++;
            mem_rsp_valid <= 1'b1;
            mem_rsp_err   <= (mem_req_addr == err_addr);
            if (mem_req_write && mem_req_addr != err_addr)
                bmem[mem_req_addr[11:2]] <= mem_req_wdata;
            mem_rsp_data <= bmem[mem_req_addr[11:2]];
        end
        if (irq_pulse) begin
            irq_cnt++;
            last_kind = irq_kind;
            last_vec  = irq_vec;
        end
    end

    always @(negedge clk) mem_req_ready <= ($urandom % 4) != 0;

    function automatic bit vec_ok(input int k, input int v);
        if (k == 0) return v == 0;
        if (k == 1) return v >= 1 && v <= 32;
        if (k == 2) return v >= 1 && v <= 2048;
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run(input logic [31:0] cmd);
        logic [31:0] c;
        irq_base = irq_cnt;
        acc_base = acc_cnt;
        wr(3'd1, cmd);
        for (int i = 0; i < 4000; i++) begin
            rd(3'd1, c);
            if (c == 0) break;
        end
        chk("R3 command self-clear", c, 0);
        @(negedge clk);
    endtask

    task automatic chk_irq(input string tag, input bit exp_fire, input int k, input int v);
        chk({tag, " pulse count"}, irq_cnt - irq_base, exp_fire ? 1 : 0);
        if (exp_fire) begin
            chk({tag, " kind"}, {30'd0, last_kind}, k);
            chk({tag, " vector"}, {16'd0, last_vec}, v);
        end
    endtask

    task automatic stat(input string tag, input logic [31:0] exp);
        logic [31:0] s;
        rd(3'd2, s);
        chk(tag, s, exp);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog act=hung exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, pat;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 1024; i++) bmem[i] = $urandom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(3'd2, v); chk("R3 status after reset", v, 0);
        rd(3'd1, v); chk("R2 command after reset", v, 0);
        rd(3'd0, v); chk("R1 pattern after reset", v, 0);

        // R1 pattern readback
        for (int i = 0; i < 4; i++) begin
            pat = $urandom;
            wr(3'd0, pat); rd(3'd0, v); chk("R1 pattern readback", v, pat);
        end

        // R4 read: 4 words, MSI vector 5
        wr(3'd6, 1); wr(3'd7, 5); wr(3'd3, 32'h100); wr(3'd5, 16);
        run(32'h08);
        stat("R4 read ok status", 32'h41);
        chk("R4 read word count", acc_cnt - acc_base, 4);
        chk_irq("R9 read irq", 1, 1, 5);

        // R5 write: 10 bytes -> 3 words
        pat = 32'hC0DE_5A17; wr(3'd0, pat);
        v = bmem[32'h83];
        wr(3'd4, 32'h200); wr(3'd5, 10);
        run(32'h10);
        stat("R5 write ok status", 32'h44);
        chk("R5 write word 0", bmem[32'h80], pat);
        chk("R5 write word 2", bmem[32'h82], pat);
        chk("R5 word past end untouched", bmem[32'h83], v);

        // R6 copy: 8 words
        wr(3'd3, 32'h300); wr(3'd4, 32'h400); wr(3'd5, 32);
        run(32'h20);
        stat("R6 copy ok status", 32'h50);
        for (int i = 0; i < 8; i++) chk("R6 copy data", bmem[32'h100 + i], bmem[32'hC0 + i]);

        // R7 misaligned source
        wr(3'd3, 32'h102); wr(3'd5, 16);
        run(32'h08);
        stat("R7 misaligned source status", 32'hC2);
        chk("R7 no request on bad source", acc_cnt - acc_base, 0);

        // R7 destination span past window
        wr(3'd3, 32'h0); wr(3'd4, 32'hFF8);
        run(32'h20);
        stat("R7 bad destination status", 32'h160);
        chk("R7 no request on bad destination", acc_cnt - acc_base, 0);

        // R8 error on third word of a read
        err_addr = 32'h508;
        wr(3'd3, 32'h500); wr(3'd5, 16);
        run(32'h08);
        stat("R8 error response status", 32'h42);
        chk("R8 stops after error", acc_cnt - acc_base, 3);
        err_addr = 32'hFFFF_FFFF;

        // R2 lowest bit wins: read+write -> read
        wr(3'd4, 32'h600); v = bmem[32'h180];
        run(32'h18);
        stat("R2 lowest bit honoured status", 32'h41);
        chk("R2 write not performed", bmem[32'h180], v);

        // R2 command while busy is ignored
        wr(3'd3, 32'h700); wr(3'd4, 32'h800); wr(3'd5, 64);
        irq_base = irq_cnt;
        wr(3'd1, 32'h20);
        wr(3'd1, 32'h10);
        rd(3'd1, v); chk("R3 command reads back while busy", v, 32'h20);
        run(32'h0);
        stat("R2 busy write ignored status", 32'h50);

        // R13 zero length with vector range edges (R9)
        wr(3'd3, 32'h10); wr(3'd5, 0);
        begin
            int ks[10] = '{0, 0, 1, 1, 1, 2, 2, 2, 3, 3};
            int vs[10] = '{0, 1, 0, 32, 33, 1, 2048, 2049, 0, 1};
            for (int i = 0; i < 10; i++) begin
                bit ok;
                ok = vec_ok(ks[i], vs[i]);
                wr(3'd6, ks[i]); wr(3'd7, vs[i]);
                run(32'h08);
                stat("R13 zero length status (R9 flag)", ok ? 32'h41 : 32'h01);
                chk("R13 zero length no access", acc_cnt - acc_base, 0);
                chk_irq("R9 range edge", ok, ks[i], vs[i]);
            end
        end

        // R10 raise-only commands
        wr(3'd6, 0); wr(3'd7, 7);
        run(32'h04);
        stat("R10 raise MSI-X status", 32'h40);
        chk_irq("R10 raise MSI-X", 1, 2, 7);
        chk("R10 raise touches no memory", acc_cnt - acc_base, 0);
        run(32'h01);
        stat("R10 raise legacy vector 7 suppressed", 32'h00);
        chk_irq("R10 raise legacy suppressed", 0, 0, 0);
        wr(3'd7, 0);
        run(32'h02);
        stat("R10 raise MSI vector 0 suppressed", 32'h00);
        run(32'h01);
        stat("R11 raise legacy flag", 32'h40);
        chk_irq("R11 raise legacy", 1, 0, 0);

        // Random copies
        wr(3'd6, 1);
        for (int it = 0; it < 30; it++) begin
            int s, d, l, w, nv, bad;
            logic [31:0] after;
            s = ($urandom % 448) * 4;
            d = 32'h800 + ($urandom % 448) * 4;
            l = $urandom % 65;
            nv = 1 + ($urandom % 40);
            w = (l + 3) / 4;
            after = bmem[(d >> 2) + w];
            wr(3'd3, s); wr(3'd4, d); wr(3'd5, l); wr(3'd7, nv);
            run(32'h20);
            stat("R6 random copy status", vec_ok(1, nv) ? 32'h50 : 32'h10);
            bad = 0;
            for (int i = 0; i < w; i++) if (bmem[(d >> 2) + i] !== bmem[(s >> 2) + i]) bad++;
            chk("R6 random copy data mismatches", bad, 0);
            chk("R6 random copy word count", acc_cnt - acc_base, 2 * w);
            chk("R6 random copy bound", bmem[(d >> 2) + w], after);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule